// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker and Reorderer

This block sits between a framebuffer fetch path and a 24-bit pixel output bus. It accepts 32-bit words over a valid/ready handshake, realigns each word by a configurable shift, and splits it into pixels. In 16-bit mode a word holds two pixels, in either a 5-6-5 or a 1-5-5-5 layout. In 32-bit mode a word holds one pixel in its lower three bytes. Narrow components are widened to 8 bits. Each pixel then leaves as three 8-bit components over a second valid/ready handshake, one pixel per cycle.

A byte-valid mask tells the block which parts of each word carry data. Half-words or words that the mask marks as empty are dropped without producing output. Each line picks its own component order, and there is a separate order code for odd lines and for even lines. A line-start pulse flips the line parity, and a frame-start pulse returns the parity to even. The block holds no framebuffer addresses, FIFOs or sync timing.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset no pixel is offered (`pix_valid` low) and a word is accepted (`word_ready` high).
- R2: A `cfg_word_len` of 3 selects 32-bit mode, and the values 1 and 2 act the same way. Each word yields one pixel taken from the aligned word, with R from bits 23:16, G from bits 15:8 and B from bits 7:0. Bits 31:24 are ignored.
- R3: A `cfg_word_len` of 0 selects 16-bit mode. The half-word in bits 15:0 is output before the half-word in bits 31:16. With `cfg_fmt_1555` low, each half-word is 5-6-5, with R in bits 15:11, G in bits 10:5 and B in bits 4:0.
- R4: With `cfg_fmt_1555` high in 16-bit mode, R is in bits 14:10, G in bits 9:5 and B in bits 4:0, and bit 15 of each half-word is ignored.
- R5: A 5-bit component v widens to {v, v[4:2]}, and a 6-bit component widens to {v, v[5:4]}.
- R6: In 16-bit mode the low half-word is used only if mask bits 1:0 are both set, and the high half-word only if mask bits 3:2 are both set. In 32-bit mode a word with mask 0 produces no pixel, and any nonzero mask produces one pixel.
- R7: Before extraction the word is shifted by `cfg_shift_amt` (0 to 31) with zero fill. The shift goes right when `cfg_shift_right` is 1 and left when it is 0. A right shift by 8 turns an R-G-B-X word into 0-R-G-B.
- R8: The order code sets `pix_data` from bits 23 down to 0 as follows: 0 RGB, 1 RBG, 2 GBR, 3 GRB, 4 BRG, 5 BGR. Codes 6 and 7 act as RGB.
- R9: Line parity is even after reset and after any `frame_start` pulse. A `line_start` pulse without `frame_start` toggles the parity. Even lines use `cfg_order_even` and odd lines use `cfg_order_odd`.
- R10: While `pix_valid` is high and `pix_ready` is low, `pix_data` holds. A new word is accepted only when no pixel is pending, or in the cycle the last pending pixel is taken. The result is one pixel per cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_len | input | 2 | Pixel size: 0 selects 16-bit, other values select 32-bit |
| cfg_fmt_1555 | input | 1 | 16-bit layout select: 1 for 1-5-5-5, 0 for 5-6-5 |
| cfg_byte_mask | input | 4 | Byte-valid mask for each word |
| cfg_shift_right | input | 1 | Shift direction: 1 right, 0 left |
| cfg_shift_amt | input | 5 | Shift amount in bits |
| cfg_order_odd | input | 3 | Component order code for odd lines |
| cfg_order_even | input | 3 | Component order code for even lines |
| frame_start | input | 1 | Pulse that forces line parity to even |
| line_start | input | 1 | Pulse that toggles line parity |
| word_valid | input | 1 | Input word valid |
| word_data | input | 32 | Input word |
| word_ready | output | 1 | Input word accepted |
| pix_valid | output | 1 | Output pixel valid |
| pix_data | output | 24 | Output pixel, components ordered as in R8 |
| pix_ready | input | 1 | Output pixel accepted |

## Verification
The assertions assume that every `cfg_*` input stays constant while a pixel is pending. They also assume that `frame_start` and `line_start` pulse only while no pixel is pending, because both the captured pixel and its order are read from this state. The stimulus changes configuration only once the output has drained, and it pulses the line markers between words. Output hold is proved under stall: the bench withholds `pix_ready` with a second word already waiting at the input.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

   typedef enum logic [2:0] {
      ORD_RGB = 3'd0,
      ORD_RBG = 3'd1,
      ORD_GBR = 3'd2,
      ORD_GRB = 3'd3,
      ORD_BRG = 3'd4,
      ORD_BGR = 3'd5,
      ORD_RSV = 3'd6,
      ORD_CLR = 3'd7
   } order_e;

   localparam logic [1:0] WLEN_HALF = 2'd0;

endpackage

// File: rtl/pxu_align.sv
module pxu_align #(
   parameter int WORD_W = 32,
   parameter int AMT_W  = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              shift_right,
   input  logic [AMT_W-1:0]  shift_amt,
   output logic [WORD_W-1:0] word_out
);
   // zero-filling barrel shift in either direction
   always_comb begin
      if (shift_right) word_out = word_in >> shift_amt;
      else             word_out = word_in << shift_amt;
   end
endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
   import pxu_pkg::*;
#(
   parameter bit WIDEN_REPLICATE = 1'b1
) (
   input  logic [15:0] half,
   input  logic [23:0] wide,
   input  logic        is_half,
   input  logic        is_1555,
   output rgb_t        px
);
   logic [4:0] r5, g5, b5;
   logic [5:0] g6;
   logic [2:0] lo_r, lo_g5, lo_b;
   logic [1:0] lo_g6;

   assign r5 = is_1555 ? half[14:10] : half[15:11];
   assign g6 = half[10:5];
   assign g5 = half[9:5];
   assign b5 = half[4:0];

   // widening variant chosen at elaboration
   generate
      if (WIDEN_REPLICATE) begin : g_replicate
         assign lo_r  = r5[4:2];
         assign lo_g5 = g5[4:2];
         assign lo_b  = b5[4:2];
         assign lo_g6 = g6[5:4];
      end else begin : g_zero_fill
         assign lo_r  = '0;
         assign lo_g5 = '0;
         assign lo_b  = '0;
         assign lo_g6 = '0;
      end
   endgenerate

   always_comb begin
      if (is_half) begin
         px.r = {r5, lo_r};
         px.g = is_1555 ? {g5, lo_g5} : {g6, lo_g6};
         px.b = {b5, lo_b};
      end else begin
         px.r = wide[23:16];
         px.g = wide[15:8];
         px.b = wide[7:0];
      end
   end
endmodule

// File: rtl/pxu_reorder.sv
module pxu_reorder
   import pxu_pkg::*;
(
   input  rgb_t        px,
   input  logic [2:0]  code,
   output logic [23:0] bus
);
   always_comb begin
      case (order_e'(code))
         ORD_RBG: bus = {px.r, px.b, px.g};
         ORD_GBR: bus = {px.g, px.b, px.r};
         ORD_GRB: bus = {px.g, px.r, px.b};
         ORD_BRG: bus = {px.b, px.r, px.g};
         ORD_BGR: bus = {px.b, px.g, px.r};
         default: bus = {px.r, px.g, px.b};
      endcase
   end
endmodule

// File: rtl/pxu_parity.sv
module pxu_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic line_start,
   output logic line_odd
);
   always_ff @(posedge clk) begin
      if (!rst_n)           line_odd <= 1'b0;
      else if (frame_start) line_odd <= 1'b0;
      else if (line_start)  line_odd <= ~line_odd;
   end

   // R9
   frame_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !line_odd);

   // R9
   line_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start) |=> (line_odd != $past(line_odd)));
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
   import pxu_pkg::*;
#(
   parameter int WORD_W          = 32,
   parameter int COMP_W          = 8,
   parameter int AMT_W           = $clog2(WORD_W),
   parameter int ORD_W           = 3,
   parameter bit WIDEN_REPLICATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_word_len,
   input  logic                cfg_fmt_1555,
   input  logic [WORD_W/8-1:0] cfg_byte_mask,
   input  logic                cfg_shift_right,
   input  logic [AMT_W-1:0]    cfg_shift_amt,
   input  logic [ORD_W-1:0]    cfg_order_odd,
   input  logic [ORD_W-1:0]    cfg_order_even,
   input  logic                frame_start,
   input  logic                line_start,
   input  logic                word_valid,
   input  logic [WORD_W-1:0]   word_data,
   output logic                word_ready,
   output logic                pix_valid,
   output logic [3*COMP_W-1:0] pix_data,
   input  logic                pix_ready
);
   localparam int HALF_W = WORD_W / 2;
   localparam int PIX_W  = 3 * COMP_W;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("pixel_unpacker: WORD_W must be 32");
      end
      if (COMP_W != 8) begin : g_bad_comp
         $error("pixel_unpacker: COMP_W must be 8");
      end
      if (ORD_W != 3) begin : g_bad_ord
         $error("pixel_unpacker: ORD_W must be 3");
      end
   endgenerate

   logic [WORD_W-1:0] aligned;
   logic [WORD_W-1:0] hold_word;
   logic              hold_half;
   logic              hold_1555;
   logic [1:0]        pend;
   logic [1:0]        lanes_in;
   logic              in_half;
   logic              one_left;
   logic              accept;
   logic              line_odd;
   logic [HALF_W-1:0] cur_half;
   logic [ORD_W-1:0]  cur_code;
   rgb_t              px;

   pxu_align #(.WORD_W(WORD_W), .AMT_W(AMT_W)) i_align (
      .word_in     (word_data),
      .shift_right (cfg_shift_right),
      .shift_amt   (cfg_shift_amt),
      .word_out    (aligned)
   );

   pxu_parity i_parity (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_start  (line_start),
      .line_odd    (line_odd)
   );

   assign in_half  = (cfg_word_len == WLEN_HALF);
   assign lanes_in = in_half ? {&cfg_byte_mask[3:2], &cfg_byte_mask[1:0]}
                             : {1'b0, |cfg_byte_mask};

   assign pix_valid  = |pend;
   assign one_left   = (pend == 2'b01) || (pend == 2'b10);
   assign word_ready = (pend == 2'b00) || (one_left && pix_ready);
   assign accept     = word_valid && word_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 2'b00;
         hold_word <= '0;
         hold_half <= 1'b0;
         hold_1555 <= 1'b0;
      end else if (accept) begin
         pend      <= lanes_in;
         hold_word <= aligned;
         hold_half <= in_half;
         hold_1555 <= cfg_fmt_1555;
      end else if (pix_valid && pix_ready) begin
         if (pend[0]) pend[0] <= 1'b0;
         else         pend[1] <= 1'b0;
      end
   end

   assign cur_half = pend[0] ? hold_word[HALF_W-1:0] : hold_word[WORD_W-1:HALF_W];
   assign cur_code = line_odd ? cfg_order_odd : cfg_order_even;

   pxu_decode #(.WIDEN_REPLICATE(WIDEN_REPLICATE)) i_decode (
      .half    (cur_half),
      .wide    (hold_word[PIX_W-1:0]),
      .is_half (hold_half),
      .is_1555 (hold_1555),
      .px      (px)
   );

   pxu_reorder i_reorder (
      .px   (px),
      .code (cur_code),
      .bus  (pix_data)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!pix_valid && word_ready));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

   // R10
   accept_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && pix_valid) |-> pix_ready);

   // R6
   drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && (cfg_word_len != 2'd0) && (cfg_byte_mask == '0))
      |=> !pix_valid);

   // R3
   two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && (cfg_word_len == 2'd0) && (&cfg_byte_mask))
      |=> (pix_valid && !word_ready));
endmodule

// File: tb/test_pixel_unpacker.sv
`timescale 1ns/1ps
module test_pixel_unpacker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_word_len = '0;
   logic        cfg_fmt_1555 = 1'b0;
   logic [3:0]  cfg_byte_mask = '0;
   logic        cfg_shift_right = 1'b0;
   logic [4:0]  cfg_shift_amt = '0;
   logic [2:0]  cfg_order_odd = 3'd5;
   logic [2:0]  cfg_order_even = 3'd0;
   logic        frame_start = 1'b0;
   logic        line_start = 1'b0;
   logic        word_valid = 1'b0;
   logic [31:0] word_data = '0;
   logic        word_ready;
   logic        pix_valid;
   logic [23:0] pix_data;
   logic        pix_ready = 1'b1;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pixel_unpacker i_pixel_unpacker (
      .clk(clk), .rst_n(rst_n),
      .cfg_word_len(cfg_word_len), .cfg_fmt_1555(cfg_fmt_1555),
      .cfg_byte_mask(cfg_byte_mask), .cfg_shift_right(cfg_shift_right),
      .cfg_shift_amt(cfg_shift_amt), .cfg_order_odd(cfg_order_odd),
      .cfg_order_even(cfg_order_even), .frame_start(frame_start),
      .line_start(line_start), .word_valid(word_valid), .word_data(word_data),
      .word_ready(word_ready), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready)
   );

   typedef struct packed {
      logic [1:0]  wl;
      logic        f1555;
      logic [3:0]  mask;
      logic        dir;
      logic [4:0]  amt;
      logic [2:0]  ord;
      logic [31:0] data;
      logic [1:0]  n;
      logic [23:0] e0;
      logic [23:0] e1;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd0, 32'hAA123456, 2'd1, 24'h123456, 24'h0,      4'd2},
      '{2'd3, 1'b0, 4'h7, 1'b0, 5'd0,  3'd5, 32'h00112233, 2'd1, 24'h332211, 24'h0,      4'd2},
      '{2'd3, 1'b0, 4'hF, 1'b1, 5'd8,  3'd0, 32'h11223344, 2'd1, 24'h112233, 24'h0,      4'd7},
      '{2'd3, 1'b0, 4'h0, 1'b0, 5'd0,  3'd0, 32'hFFFFFFFF, 2'd0, 24'h0,      24'h0,      4'd6},
      '{2'd0, 1'b0, 4'hF, 1'b0, 5'd0,  3'd0, 32'hFFFFF800, 2'd2, 24'hFF0000, 24'hFFFFFF, 4'd3},
      '{2'd0, 1'b0, 4'hF, 1'b0, 5'd0,  3'd0, 32'h001F07E0, 2'd2, 24'h00FF00, 24'h0000FF, 4'd3},
      '{2'd0, 1'b0, 4'hF, 1'b0, 5'd0,  3'd0, 32'h00008410, 2'd2, 24'h848284, 24'h000000, 4'd5},
      '{2'd0, 1'b1, 4'hF, 1'b0, 5'd0,  3'd0, 32'h7C008000, 2'd2, 24'h000000, 24'hFF0000, 4'd4},
      '{2'd0, 1'b1, 4'hF, 1'b0, 5'd0,  3'd0, 32'hFFFF03E0, 2'd2, 24'h00FF00, 24'hFFFFFF, 4'd4},
      '{2'd0, 1'b0, 4'h3, 1'b0, 5'd0,  3'd0, 32'hFFFFF800, 2'd1, 24'hFF0000, 24'h0,      4'd6},
      '{2'd0, 1'b0, 4'hC, 1'b0, 5'd0,  3'd0, 32'h001FF800, 2'd1, 24'h0000FF, 24'h0,      4'd6},
      '{2'd0, 1'b0, 4'h6, 1'b0, 5'd0,  3'd0, 32'hFFFFFFFF, 2'd0, 24'h0,      24'h0,      4'd6},
      '{2'd0, 1'b0, 4'h9, 1'b0, 5'd0,  3'd0, 32'hFFFFFFFF, 2'd0, 24'h0,      24'h0,      4'd6},
      '{2'd0, 1'b0, 4'hF, 1'b0, 5'd16, 3'd0, 32'h0000F800, 2'd2, 24'h000000, 24'hFF0000, 4'd7},
      '{2'd3, 1'b0, 4'hF, 1'b1, 5'd4,  3'd0, 32'h0ABCDEF0, 2'd1, 24'hABCDEF, 24'h0,      4'd7},
      '{2'd3, 1'b0, 4'hF, 1'b1, 5'd31, 3'd0, 32'h80000000, 2'd1, 24'h000001, 24'h0,      4'd7},
      '{2'd1, 1'b0, 4'hF, 1'b0, 5'd0,  3'd0, 32'h00ABCDEF, 2'd1, 24'hABCDEF, 24'h0,      4'd2},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd1, 32'h00112233, 2'd1, 24'h113322, 24'h0,      4'd8},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd2, 32'h00112233, 2'd1, 24'h223311, 24'h0,      4'd8},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd3, 32'h00112233, 2'd1, 24'h221133, 24'h0,      4'd8},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd4, 32'h00112233, 2'd1, 24'h331122, 24'h0,      4'd8},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd6, 32'h00112233, 2'd1, 24'h112233, 24'h0,      4'd8},
      '{2'd3, 1'b0, 4'hF, 1'b0, 5'd0,  3'd7, 32'h00112233, 2'd1, 24'h112233, 24'h0,      4'd8},
      '{2'd0, 1'b1, 4'hF, 1'b0, 5'd0,  3'd0, 32'h7BDE0421, 2'd2, 24'h080808, 24'hF7F7F7, 4'd5},
      '{2'd2, 1'b0, 4'hC, 1'b0, 5'd0,  3'd0, 32'h00102030, 2'd1, 24'h102030, 24'h0,      4'd6}
   };

   function automatic string rq_name(input logic [3:0] r);
      case (r)
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // push one word at a negedge and check the pixels that follow
   task automatic push_and_check(input string req, input logic [31:0] data,
                                 input int n, input logic [23:0] e0,
                                 input logic [23:0] e1);
      word_data  = data;
      word_valid = 1'b1;
      @(negedge clk);
      word_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         check(req, "pix_valid", {31'b0, pix_valid}, 32'd1);
         check(req, "pix_data", {8'b0, pix_data}, {8'b0, (k == 0) ? e0 : e1});
         @(negedge clk);
      end
      check(req, "drained", {31'b0, pix_valid}, 32'd0);
   endtask

   task automatic pulse(input bit fs, input bit ls);
      frame_start = fs;
      line_start  = ls;
      @(negedge clk);
      frame_start = 1'b0;
      line_start  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R10 watchdog: actual hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "pix_valid after reset", {31'b0, pix_valid}, 32'd0);
      check("R1", "word_ready after reset", {31'b0, word_ready}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         cfg_word_len    = VECS[i].wl;
         cfg_fmt_1555    = VECS[i].f1555;
         cfg_byte_mask   = VECS[i].mask;
         cfg_shift_right = VECS[i].dir;
         cfg_shift_amt   = VECS[i].amt;
         cfg_order_even  = VECS[i].ord;
         cfg_order_odd   = 3'd5;
         push_and_check(rq_name(VECS[i].rq), VECS[i].data, int'(VECS[i].n),
                        VECS[i].e0, VECS[i].e1);
      end

      // R9 line parity: even uses code 0, odd uses code 5 (BGR)
      cfg_word_len = 2'd3; cfg_byte_mask = 4'hF; cfg_shift_amt = '0;
      cfg_order_even = 3'd0; cfg_order_odd = 3'd5;
      pulse(1'b0, 1'b1);
      push_and_check("R9", 32'h00112233, 1, 24'h332211, 24'h0);
      pulse(1'b0, 1'b1);
      push_and_check("R9", 32'h00112233, 1, 24'h112233, 24'h0);
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b1);
      push_and_check("R9", 32'h00112233, 1, 24'h112233, 24'h0);
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      push_and_check("R9", 32'h00112233, 1, 24'h112233, 24'h0);

      // R10 backpressure with a second word waiting
      cfg_word_len = 2'd0; cfg_fmt_1555 = 1'b0; cfg_byte_mask = 4'hF;
      pix_ready  = 1'b0;
      word_data  = 32'h001FF800;
      word_valid = 1'b1;
      @(negedge clk);
      word_data = 32'h07E0FFFF;
      check("R10", "stall pix_data", {8'b0, pix_data}, 32'h00FF0000);
      check("R10", "stall word_ready", {31'b0, word_ready}, 32'd0);
      @(negedge clk);
      check("R10", "held pix_data", {8'b0, pix_data}, 32'h00FF0000);
      check("R10", "held pix_valid", {31'b0, pix_valid}, 32'd1);
      check("R10", "held word_ready", {31'b0, word_ready}, 32'd0);
      pix_ready = 1'b1;
      @(negedge clk);
      check("R10", "second lane", {8'b0, pix_data}, 32'h000000FF);
      check("R10", "ready on last lane", {31'b0, word_ready}, 32'd1);
      @(negedge clk);
      word_valid = 1'b0;
      check("R10", "next word lane 0", {8'b0, pix_data}, 32'h00FFFFFF);
      check("R10", "next word valid", {31'b0, pix_valid}, 32'd1);
      @(negedge clk);
      check("R10", "next word lane 1", {8'b0, pix_data}, 32'h0000FF00);
      @(negedge clk);
      check("R10", "drained", {31'b0, pix_valid}, 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule